// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, each cycle, which hardware thread of a multithreaded front end may use the fetch slot. Every thread reports a three-bit status, an active mask says which threads exist right now, and a policy input chooses how the winner is picked. The outcome is a grant flag and the granted thread number, both formed combinationally from the present inputs and the stored round-robin order.

For round-robin the block holds a priority order of thread numbers. The front of the order is searched first. When the fetch unit accepts a round-robin grant, only the granted thread moves to the back of the order; the others keep their relative positions. Two occupancy-driven policies favour the thread with the fullest instruction queue or load/store queue. Built with a single thread, the block skips all policy logic.

Top module: `fetch_thread_picker`

## Requirements
- R1: A thread is eligible only when its active bit is set and its status code is 0 (running), 1 (idle) or 4 (cache line returned); codes 2, 3, 5, 6 and 7 are never eligible. Status of thread t sits in status_i[3t+2:3t].
- R2: Policy codes are 0 single, 1 round-robin, 2 instruction-queue count, 3 load/store-queue count, 4 first-active; codes 5 to 7 give no grant.
- R3: With policy 0 and more than one thread, the grant is always valid with thread 0.
- R4: With policy 1 the grant is the first eligible thread found when scanning the priority order from its front.
- R5: The priority order changes only on a clock edge where take_i is high, the grant is valid and policy is 1; then the granted thread moves to the back and the threads behind it move forward by one place.
- R6: With policy 2 the grant is the eligible thread with the largest count in iq_cnt_i (thread t at bits [CNT_W*t+CNT_W-1:CNT_W*t]); equal counts go to the lower thread number.
- R7: With policy 3 the same rule as R6 applies to lsq_cnt_i.
- R8: With policy 4 the grant is the lowest-numbered active thread, whatever its status; no active thread means no grant.
- R9: Under policies 1, 2 and 3, when no thread is eligible the grant flag is low.
- R10: After reset the priority order is thread 0, 1, 2 and upward.
- R11: When built with one thread, the grant is valid with thread 0 exactly when thread 0 is eligible, for every policy code.
- R12: The grant follows the inputs in the same cycle, with no register between inputs and grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | 3*NTHREADS | Per-thread status codes |
| active_i | input | NTHREADS | Active-thread mask |
| policy_i | input | 3 | Selection policy code |
| iq_cnt_i | input | CNT_W*NTHREADS | Per-thread instruction-queue occupancy |
| lsq_cnt_i | input | CNT_W*NTHREADS | Per-thread load/store-queue occupancy |
| take_i | input | 1 | Fetch unit accepts the current grant |
| grant_valid_o | output | 1 | A thread is granted this cycle |
| grant_tid_o | output | TID_W | Granted thread number |

## Verification
The bench builds two copies: one with four threads and four-bit counts, where random statuses, masks, counts and policies drive rotations from every list position and frequent count ties, and one with a single thread, which reaches the bypass path under every policy code. A behavioural model keeps the round-robin order as a queue and is compared against both copies every cycle.

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker #(
  parameter int NTHREADS = 4,
  parameter int CNT_W    = 6,
  parameter int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3*NTHREADS-1:0]     status_i,
  input  logic [NTHREADS-1:0]       active_i,
  input  logic [2:0]                policy_i,
  input  logic [CNT_W*NTHREADS-1:0] iq_cnt_i,
  input  logic [CNT_W*NTHREADS-1:0] lsq_cnt_i,
  input  logic                      take_i,
  output logic                      grant_valid_o,
  output logic [TID_W-1:0]          grant_tid_o
);
  localparam logic [2:0] ST_RUN  = 3'd0;
  localparam logic [2:0] ST_IDLE = 3'd1;
  localparam logic [2:0] ST_DONE = 3'd4;

  localparam logic [2:0] POL_SINGLE = 3'd0;
  localparam logic [2:0] POL_RR     = 3'd1;
  localparam logic [2:0] POL_IQ     = 3'd2;
  localparam logic [2:0] POL_LSQ    = 3'd3;
  localparam logic [2:0] POL_FIRST  = 3'd4;

  localparam int LIST_W = TID_W * NTHREADS;

  logic [NTHREADS-1:0] elig;
  logic [TID_W-1:0]    order [NTHREADS];
  logic [LIST_W-1:0]   order_q;

  logic             rr_hit, mx_hit, fa_hit;
  logic [TID_W-1:0] rr_tid, rr_pos, mx_tid, fa_tid;
  logic [CNT_W-1:0] mx_cnt, cur_cnt;
  logic             sel_valid;
  logic [TID_W-1:0] sel_tid;

  always_comb begin
    for (int t = 0; t < NTHREADS; t++) begin
      elig[t] = active_i[t] &&
                (status_i[3*t +: 3] == ST_RUN || status_i[3*t +: 3] == ST_IDLE ||
                 status_i[3*t +: 3] == ST_DONE);
      order[t] = order_q[t*TID_W +: TID_W];
    end

    rr_hit = 1'b0;
    rr_tid = '0;
    rr_pos = '0;
    for (int p = 0; p < NTHREADS; p++) begin
      if (!rr_hit && elig[order[p]]) begin
        rr_hit = 1'b1;
        rr_tid = order[p];
        rr_pos = TID_W'(p);
      end
    end

    mx_hit = 1'b0;
    mx_tid = '0;
    mx_cnt = '0;
    for (int t = 0; t < NTHREADS; t++) begin
      cur_cnt = (policy_i == POL_LSQ) ? lsq_cnt_i[t*CNT_W +: CNT_W] : iq_cnt_i[t*CNT_W +: CNT_W];
      if (elig[t] && (!mx_hit || cur_cnt > mx_cnt)) begin
        mx_hit = 1'b1;
        mx_tid = TID_W'(t);
        mx_cnt = cur_cnt;
      end
    end

    fa_hit = 1'b0;
    fa_tid = '0;
    for (int t = NTHREADS - 1; t >= 0; t--) begin
      if (active_i[t]) begin
        fa_hit = 1'b1;
        fa_tid = TID_W'(t);
      end
    end

    case (policy_i)
      POL_SINGLE:      begin sel_valid = 1'b1;   sel_tid = '0;     end
      POL_RR:          begin sel_valid = rr_hit; sel_tid = rr_tid; end
      POL_IQ, POL_LSQ: begin sel_valid = mx_hit; sel_tid = mx_tid; end
      POL_FIRST:       begin sel_valid = fa_hit; sel_tid = fa_tid; end
      default:         begin sel_valid = 1'b0;   sel_tid = '0;     end
    endcase
  end

  wire rotate = (NTHREADS > 1) && take_i && rr_hit && policy_i == POL_RR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NTHREADS; p++) order_q[p*TID_W +: TID_W] <= TID_W'(p);
    end else if (rotate) begin
      for (int p = 0; p < NTHREADS - 1; p++)
        if (p >= int'(rr_pos)) order_q[p*TID_W +: TID_W] <= order[p+1];
      order_q[(NTHREADS-1)*TID_W +: TID_W] <= rr_tid;
    end
  end

  generate
    if (NTHREADS == 1) begin : g_bypass
      assign grant_valid_o = elig[0];
      assign grant_tid_o   = '0;

      assert_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o == (active_i[0] && (status_i[2:0] == ST_RUN ||
                          status_i[2:0] == ST_IDLE || status_i[2:0] == ST_DONE)));
    end else begin : g_multi
      assign grant_valid_o = sel_valid;
      assign grant_tid_o   = sel_tid;

      logic [2:0]       g_st;
      logic             beaten;
      logic [CNT_W-1:0] g_cnt, o_cnt;
      assign g_st = status_i[3*grant_tid_o +: 3];

      always_comb begin
        beaten = 1'b0;
        g_cnt = (policy_i == POL_LSQ) ? lsq_cnt_i[grant_tid_o*CNT_W +: CNT_W]
                                      : iq_cnt_i[grant_tid_o*CNT_W +: CNT_W];
        for (int t = 0; t < NTHREADS; t++) begin
          o_cnt = (policy_i == POL_LSQ) ? lsq_cnt_i[t*CNT_W +: CNT_W] : iq_cnt_i[t*CNT_W +: CNT_W];
          if (elig[t] && (o_cnt > g_cnt || (o_cnt == g_cnt && t < int'(grant_tid_o))))
            beaten = 1'b1;
        end
      end

      assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && (policy_i == POL_RR || policy_i == POL_IQ || policy_i == POL_LSQ))
        |-> (active_i[grant_tid_o] && (g_st == ST_RUN || g_st == ST_IDLE || g_st == ST_DONE)));

      assert_bad_policy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i > POL_FIRST) |-> !grant_valid_o);

      assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == POL_SINGLE) |-> (grant_valid_o && grant_tid_o == '0));

      assert_rr_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && grant_valid_o && policy_i == POL_RR)
        |=> (order_q[(NTHREADS-1)*TID_W +: TID_W] == $past(grant_tid_o)));

      assert_rr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_i && grant_valid_o && policy_i == POL_RR) |=> $stable(order_q));

      assert_best_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && (policy_i == POL_IQ || policy_i == POL_LSQ)) |-> !beaten);

      assert_idle_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && (policy_i == POL_RR || policy_i == POL_IQ || policy_i == POL_LSQ))
        |-> (elig == '0));
    end
  endgenerate
endmodule

// File: tb/tb_fetch_thread_picker.sv
module tb_fetch_thread_picker;
  localparam int N  = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3*N-1:0]  status;
  logic [N-1:0]    active;
  logic [2:0]      policy;
  logic [CW*N-1:0] iq, lsq;
  logic            take;
  logic            gv;
  logic [1:0]      gt;

  logic [2:0]      status1;
  logic            active1;
  logic [CW-1:0]   iq1, lsq1;
  logic            gv1;
  logic [0:0]      gt1;

  fetch_thread_picker #(.NTHREADS(N), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .status_i(status), .active_i(active), .policy_i(policy),
    .iq_cnt_i(iq), .lsq_cnt_i(lsq), .take_i(take), .grant_valid_o(gv), .grant_tid_o(gt));

  fetch_thread_picker #(.NTHREADS(1), .CNT_W(CW)) dut1 (
    .clk(clk), .rst_n(rst_n), .status_i(status1), .active_i(active1), .policy_i(policy),
    .iq_cnt_i(iq1), .lsq_cnt_i(lsq1), .take_i(take), .grant_valid_o(gv1), .grant_tid_o(gt1));

  int checks = 0, fails = 0;
  int prio[$];
  bit finished = 0;

  function automatic bit ok_st(input logic [2:0] s);
    return s == 3'd0 || s == 3'd1 || s == 3'd4;
  endfunction

  function automatic bit elig(input int t);
    return active[t] && ok_st(status[3*t +: 3]);
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (policy %0d)", tag, act, exp, policy);
    end
  endtask

  task automatic check_cycle(output int rot_idx);
    bit ev; int et; string tag; int best;
    ev = 0; et = 0; rot_idx = -1; best = -1;
    case (policy)
      3'd0: begin tag = "R3"; ev = 1; et = 0; end
      3'd1: begin
        tag = "R4";
        foreach (prio[i]) if (!ev && elig(prio[i])) begin ev = 1; et = prio[i]; rot_idx = i; end
      end
      3'd2, 3'd3: begin
        tag = (policy == 3'd2) ? "R6" : "R7";
        for (int t = 0; t < N; t++) begin
          int c;
          c = (policy == 3'd2) ? int'(iq[t*CW +: CW]) : int'(lsq[t*CW +: CW]);
          if (elig(t) && c > best) begin best = c; ev = 1; et = t; end
        end
      end
      3'd4: begin
        tag = "R8";
        for (int t = N - 1; t >= 0; t--) if (active[t]) begin ev = 1; et = t; end
      end
      default: tag = "R2";
    endcase
    if (!ev && (policy == 3'd1 || policy == 3'd2 || policy == 3'd3)) tag = "R9";
    cmp({tag, " valid"}, int'(gv), int'(ev));
    if (ev) cmp({tag, " tid"}, int'(gt), et);
    cmp("R11 valid", int'(gv1), int'(active1 && ok_st(status1)));
    if (gv1) cmp("R11 tid", int'(gt1), 0);
  endtask

  task automatic set_all(input logic [2:0] s, input logic [N-1:0] a, input logic [2:0] p);
    for (int t = 0; t < N; t++) status[3*t +: 3] = s;
    active = a; policy = p;
  endtask

  task automatic step;
    int ri;
    #3;
    check_cycle(ri);
    if (take && policy == 3'd1 && ri >= 0) begin
      int v; v = prio[ri]; prio.delete(ri); prio.push_back(v);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < N; t++) prio.push_back(t);
    set_all(3'd0, '1, 3'd1);
    iq = '0; lsq = '0; take = 1'b0;
    status1 = 3'd0; active1 = 1'b1; iq1 = '0; lsq1 = '0;
    repeat (3) @(posedge clk);
    #4;
    // R10: order after reset starts at thread 0; R12: grant visible in the same cycle
    cmp("R10 reset valid", int'(gv), 1);
    cmp("R10 reset tid", int'(gt), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R5: accepted round-robin grants walk 0,1,2,3,0
    take = 1'b1;
    repeat (6) step();
    // R5: no rotation without take
    take = 1'b0;
    repeat (3) step();
    // R1: blocked and waiting statuses are skipped
    status[3*0 +: 3] = 3'd3; status[3*1 +: 3] = 3'd5; take = 1'b1;
    repeat (4) step();
    // R9: nothing eligible
    set_all(3'd2, '1, 3'd1); repeat (2) step();
    set_all(3'd6, '1, 3'd2); repeat (2) step();
    // R6 ties go to lower thread
    set_all(3'd1, '1, 3'd2); iq = {4'd5, 4'd9, 4'd9, 4'd2}; step();
    // R7
    policy = 3'd3; lsq = {4'd7, 4'd1, 4'd3, 4'd7}; step();
    // R8 ignores status
    set_all(3'd7, 4'b1100, 3'd4); step();
    // R2 bad codes
    policy = 3'd6; step(); policy = 3'd7; step();
    // R3
    set_all(3'd3, '0, 3'd0); step();

    for (int k = 0; k < 4000; k++) begin
      for (int t = 0; t < N; t++) begin
        status[3*t +: 3] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
        iq[t*CW +: CW]  = CW'($urandom_range(0, 3));
        lsq[t*CW +: CW] = CW'($urandom_range(0, 3));
      end
      active  = N'($urandom);
      policy  = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'd1;
      take    = 1'($urandom);
      status1 = 3'($urandom_range(0, 7));
      active1 = 1'($urandom);
      iq1 = CW'($urandom); lsq1 = CW'($urandom);
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule